// File: doc/BRIEF.md
# BCD Real-Time Clock Core

A byte-wide real-time clock peripheral that keeps time of day and calendar date in packed BCD (tens digit in bits 7:4, units in bits 3:0). A counter clocked by the system clock produces one update per second, and each update advances the clock by one second. The carry runs through minutes, 24-hour hours, weekday, day of month, month and a two-digit year, with month lengths and leap years handled. A second counter drives a periodic interrupt pulse at a fixed 1024 Hz.

Software reaches the block through a simple register bus: an address, write data with a write strobe, and a read strobe. Read data is combinational from the address. The two control registers work as follows:

- Control A carries a divider code. Two of its values park the divider. When the divider leaves the parked state, the first update comes half a second later.
- Control B carries a set/halt flag and the periodic-interrupt enable. Its other bits are plain storage.
- Status registers C and D always read as zero.

Top module: `bcd_rtc`

## Requirements
- R1: Address map: seconds 0x00, minutes 0x02, hours 0x04, weekday 0x06, day of month 0x07, month 0x08, year 0x09. Each of these is a packed BCD byte. Addresses 0x01, 0x03 and 0x05 are plain read/write bytes. Addresses above 0x0D read 0x00.
- R2: Each update adds one second. Seconds 59 wraps to 00 and carries into minutes. Minutes 59 wraps to 00 and carries into hours. Hours 23 wraps to 00 and carries into the date.
- R3: A day carry advances the day of month, which wraps to 01 after the last day of the month. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the BCD year is divisible by 4 (00 included) and 28 days otherwise. All other months have 31 days. Month 12 wraps to 01 and carries into the year, which wraps from 99 to 00.
- R4: A day carry advances the weekday from 1 to 7, and 7 wraps to 1.
- R5: While bit 7 of control B (address 0x0B) is 1, updates leave every time field unchanged. Writes still take effect.
- R6: Control A (address 0x0A) bits 6:4 hold the divider code. Codes 110 and 111 stop all updates.
- R7: After a write of code 010 into a parked divider, the first update lands SEC_CYCLES/2 clock cycles after the write edge. Later updates follow every SEC_CYCLES cycles.
- R8: Bit 7 of control A is read-only to writes. It inverts after every read strobe to 0x0A, so successive reads alternate.
- R9: Addresses 0x0C and 0x0D read 0x00, and writes to them have no effect.
- R10: Reset leaves the following state:
  - control A reads 0x26 (divider 010, rate field 0110, bit 7 = 0);
  - control B reads 0x42 (bit 6 periodic enable = 1, bit 1 24-hour = 1, bit 2 data mode = 0 for BCD);
  - the clock fields read 00:00:00, weekday 01, date 01-01-00.
- R11: While bit 6 of control B is 1, irq_o pulses high for one cycle every SEC_CYCLES/1024 cycles. While that bit is 0, irq_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one byte per cycle |
| rd_i | input | 1 | Read strobe (side effect on control A only) |
| rdata_o | output | 8 | Read data for addr_i |
| irq_o | output | 1 | Periodic interrupt pulse |

## Verification
The bench parks the divider, loads a date, and releases the divider. It then samples just before and just after the half-second point, which catches a counter that restarts from zero (too late by half a second) or never parks (random phase). Every month-end is checked in a leap year and a non-leap year, along with year 00 and the 99 to 00 wrap. A wrong month-length table or a leap rule that ignores the tens digit shows up as a bad day or month after the update. The halt flag, both parked codes and the read-toggled status bit are each checked by reading time or register A before and after the event. A design that ignored any of them would show a field moving or a bit failing to alternate.

// File: rtl/bcd_rtc.sv
module bcd_rtc #(
  parameter int SEC_CYCLES = 32768,
  parameter int PIR_HZ     = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  input  logic       wr_i,
  input  logic       rd_i,
  output logic [7:0] rdata_o,
  output logic       irq_o
);
  localparam int HALF       = SEC_CYCLES / 2;
  localparam int CW         = $clog2(SEC_CYCLES);
  localparam int PIR_CYCLES = (SEC_CYCLES / PIR_HZ < 1) ? 1 : SEC_CYCLES / PIR_HZ;
  localparam int PW         = (PIR_CYCLES > 1) ? $clog2(PIR_CYCLES) : 1;

  logic [7:0]    clk_q [0:9];
  logic [6:0]    reg_a;
  logic          uip_q;
  logic [7:0]    reg_b;
  logic [CW-1:0] sec_cnt;
  logic [PW-1:0] pir_cnt;

  logic       div_off, tick, upd;
  logic [7:0] nxt [0:9];
  logic [9:0] adv;
  logic [7:0] last_day;
  logic [4:0] yr_mod;
  logic       leap, c_min, c_hr, c_day, c_mon, c_yr;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  assign div_off = reg_a[6:5] == 2'b11;
  assign tick    = !div_off && sec_cnt == CW'(SEC_CYCLES - 1);
  assign upd     = tick && !reg_b[7];
  assign irq_o   = reg_b[6] && pir_cnt == PW'(PIR_CYCLES - 1);

  // 10*t + u is congruent to 2*t + u modulo 4
  assign yr_mod = {clk_q[9][7:4], 1'b0} + {1'b0, clk_q[9][3:0]};
  assign leap   = yr_mod[1:0] == 2'b00;

  always_comb begin
    case (clk_q[8])
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  assign c_min = clk_q[0] == 8'h59;
  assign c_hr  = c_min && clk_q[2] == 8'h59;
  assign c_day = c_hr && clk_q[4] == 8'h23;
  assign c_mon = c_day && clk_q[7] == last_day;
  assign c_yr  = c_mon && clk_q[8] == 8'h12;

  always_comb begin
    for (int i = 0; i < 10; i++) nxt[i] = clk_q[i];
    adv    = '0;
    adv[0] = 1'b1;
    adv[2] = c_min;
    adv[4] = c_hr;
    adv[6] = c_day;
    adv[7] = c_day;
    adv[8] = c_mon;
    adv[9] = c_yr;
    nxt[0] = c_min ? 8'h00 : bcd_inc(clk_q[0]);
    nxt[2] = (clk_q[2] == 8'h59) ? 8'h00 : bcd_inc(clk_q[2]);
    nxt[4] = (clk_q[4] == 8'h23) ? 8'h00 : bcd_inc(clk_q[4]);
    nxt[6] = (clk_q[6] == 8'h07) ? 8'h01 : bcd_inc(clk_q[6]);
    nxt[7] = (clk_q[7] == last_day) ? 8'h01 : bcd_inc(clk_q[7]);
    nxt[8] = (clk_q[8] == 8'h12) ? 8'h01 : bcd_inc(clk_q[8]);
    nxt[9] = (clk_q[9] == 8'h99) ? 8'h00 : bcd_inc(clk_q[9]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 10; i++) clk_q[i] <= (i >= 6 && i <= 8) ? 8'h01 : 8'h00;
    end else begin
      for (int i = 0; i < 10; i++) begin
        if (wr_i && addr_i == 8'(i)) clk_q[i] <= wdata_i;
        else if (upd && adv[i])      clk_q[i] <= nxt[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_a <= 7'h26;
      uip_q <= 1'b0;
      reg_b <= 8'h42;
    end else begin
      if (wr_i && addr_i == 8'h0A) reg_a <= wdata_i[6:0];
      if (wr_i && addr_i == 8'h0B) reg_b <= wdata_i;
      if (rd_i && addr_i == 8'h0A) uip_q <= ~uip_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               sec_cnt <= '0;
    else if (div_off)         sec_cnt <= CW'(HALF);
    else if (tick)            sec_cnt <= '0;
    else                      sec_cnt <= sec_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pir_cnt <= '0;
    else if (!reg_b[6])       pir_cnt <= '0;
    else if (irq_o)           pir_cnt <= '0;
    else                      pir_cnt <= pir_cnt + 1'b1;
  end

  always_comb begin
    if (addr_i < 8'h0A)       rdata_o = clk_q[addr_i[3:0]];
    else if (addr_i == 8'h0A) rdata_o = {uip_q, reg_a};
    else if (addr_i == 8'h0B) rdata_o = reg_b;
    else                      rdata_o = 8'h00;
  end
endmodule

module bcd_rtc_checks #(
  parameter int PIR = 32
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] addr_i,
  input logic       wr_i,
  input logic       rd_i,
  input logic [7:0] rdata_o,
  input logic       irq_o,
  input logic       set_bit,
  input logic       pie_bit,
  input logic       dis,
  input logic       uip,
  input logic [7:0] sec
);
  p_set_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_bit && !wr_i) |=> $stable(sec));

  p_div_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dis && !wr_i) |=> $stable(sec));

  p_uip_flip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i == 8'h0A) |=> (uip != $past(uip)));

  p_uip_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_i && addr_i == 8'h0A) |=> $stable(uip));

  p_cd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == 8'h0C || addr_i == 8'h0D) |-> rdata_o == 8'h00);

  p_irq_width_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (PIR > 1 && irq_o) |=> !irq_o);

  p_irq_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (PIR > 1 && !pie_bit) |=> !irq_o);
endmodule

bind bcd_rtc bcd_rtc_checks #(.PIR(PIR_CYCLES)) u_checks (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
  .rdata_o(rdata_o), .irq_o(irq_o), .set_bit(reg_b[7]), .pie_bit(reg_b[6]),
  .dis(div_off), .uip(uip_q), .sec(clk_q[0])
);

// File: tb/tb_bcd_rtc.sv
module tb_bcd_rtc;
  localparam int SEC  = 2048;
  localparam int HALF = SEC / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] rdata;
  logic       irq;
  int         n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  bcd_rtc #(.SEC_CYCLES(SEC)) dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr),
    .rd_i(rd), .rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(logic [7:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd = 1'b1; #1 v = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic peek(logic [7:0] a, output logic [7:0] v);
    addr = a; #1 v = rdata;
  endtask

  task automatic load(int s, int mi, int h, int dw, int d, int mo, int y);
    wr_reg(8'h00, bcd(s));  wr_reg(8'h02, bcd(mi)); wr_reg(8'h04, bcd(h));
    wr_reg(8'h06, bcd(dw)); wr_reg(8'h07, bcd(d));  wr_reg(8'h08, bcd(mo));
    wr_reg(8'h09, bcd(y));
  endtask

  task automatic expect_time(string tag, int s, int mi, int h, int dw, int d, int mo, int y);
    logic [7:0] v;
    peek(8'h00, v); check({tag, " R2 sec"}, v, bcd(s));
    peek(8'h02, v); check({tag, " R2 min"}, v, bcd(mi));
    peek(8'h04, v); check({tag, " R2 hour"}, v, bcd(h));
    peek(8'h06, v); check({tag, " R4 weekday"}, v, bcd(dw));
    peek(8'h07, v); check({tag, " R3 day"}, v, bcd(d));
    peek(8'h08, v); check({tag, " R3 month"}, v, bcd(mo));
    peek(8'h09, v); check({tag, " R1 R3 year"}, v, bcd(y));
  endtask

  // park divider, load, release, check exactly at the half-second edge
  task automatic run_case(int s, int mi, int h, int dw, int d, int mo, int y, bit second_tick);
    logic [7:0] v;
    int ns = s, nmi = mi, nh = h, ndw = dw, nd = d, nmo = mo, ny = y;
    wr_reg(8'h0A, 8'h66);
    load(s, mi, h, dw, d, mo, y);
    wr_reg(8'h0A, 8'h26);
    repeat (HALF - 1) @(negedge clk);
    peek(8'h00, v); check("R7 before half second", v, bcd(s));
    @(negedge clk);
    ns++;
    if (ns == 60) begin ns = 0; nmi++; end
    if (nmi == 60) begin nmi = 0; nh++; end
    if (nh == 24) begin
      nh = 0; ndw = ndw % 7 + 1; nd++;
      if (nd > dim(mo, y)) begin
        nd = 1; nmo++;
        if (nmo == 13) begin nmo = 1; ny = (ny + 1) % 100; end
      end
    end
    expect_time("update", ns, nmi, nh, ndw, nd, nmo, ny);
    if (second_tick) begin
      repeat (SEC - 1) @(negedge clk);
      peek(8'h00, v); check("R7 before next second", v, bcd(ns));
      @(negedge clk);
      peek(8'h00, v); check("R7 next second", v, bcd(ns + 1));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int pulses;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    expect_time("R10 reset", 0, 0, 0, 1, 1, 1, 0);
    peek(8'h0B, v); check("R10 control B", v, 8'h42);
    // R8 toggling status bit
    rd_reg(8'h0A, v); check("R10 R8 read 1", v, 8'h26);
    rd_reg(8'h0A, v); check("R8 read 2", v, 8'hA6);
    rd_reg(8'h0A, v); check("R8 read 3", v, 8'h26);
    wr_reg(8'h0A, 8'h26);
    rd_reg(8'h0A, v); check("R8 write keeps bit", v, 8'hA6);
    wr_reg(8'h0A, 8'hA6);
    rd_reg(8'h0A, v); check("R8 write keeps bit 0", v, 8'h26);

    // R9 status C/D
    wr_reg(8'h0C, 8'hFF); rd_reg(8'h0C, v); check("R9 reg C", v, 8'h00);
    wr_reg(8'h0D, 8'h5A); rd_reg(8'h0D, v); check("R9 reg D", v, 8'h00);
    // R1 plain storage
    wr_reg(8'h01, 8'h5A); rd_reg(8'h01, v); check("R1 storage 01", v, 8'h5A);
    wr_reg(8'h05, 8'hC3); rd_reg(8'h05, v); check("R1 storage 05", v, 8'hC3);
    rd_reg(8'h20, v); check("R1 unmapped", v, 8'h00);

    // R11 periodic pulses
    pulses = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (irq) pulses++; end
    check("R11 pulses enabled", 8'(pulses), 8'd100);
    wr_reg(8'h0B, 8'h02);
    pulses = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (irq) pulses++; end
    check("R11 pulses disabled", 8'(pulses), 8'd0);
    wr_reg(8'h0B, 8'h42);

    // R2 time carries
    run_case(56, 34, 12, 3, 15, 6, 23, 1'b1);
    run_case(59, 59, 10, 2, 10, 3, 77, 1'b0);
    run_case(59, 59, 23, 7, 14, 8, 50, 1'b0);
    // R3 month ends, leap and non-leap years
    for (int m = 1; m <= 12; m++) begin
      run_case(59, 59, 23, m % 7 + 1, dim(m, 23), m, 23, 1'b0);
      run_case(59, 59, 23, m % 7 + 1, dim(m, 24), m, 24, 1'b0);
    end
    run_case(59, 59, 23, 5, 28, 2, 0, 1'b0);
    run_case(59, 59, 23, 6, 29, 2, 0, 1'b0);
    run_case(59, 59, 23, 4, 28, 2, 10, 1'b0);
    run_case(59, 59, 23, 6, 31, 12, 99, 1'b0);
    run_case(59, 59, 23, 6, 31, 12, 49, 1'b0);

    // R5 halt flag
    wr_reg(8'h0A, 8'h66);
    load(30, 20, 10, 2, 5, 5, 21);
    wr_reg(8'h0B, 8'hC2);
    wr_reg(8'h0A, 8'h26);
    repeat (2 * SEC) @(negedge clk);
    expect_time("R5 halted", 30, 20, 10, 2, 5, 5, 21);
    wr_reg(8'h0B, 8'h42);
    repeat (HALF + 10) @(negedge clk);
    expect_time("R5 resumed", 31, 20, 10, 2, 5, 5, 21);

    // R6 both parked codes
    wr_reg(8'h0A, 8'h76);
    load(0, 0, 0, 1, 1, 1, 30);
    repeat (2 * SEC) @(negedge clk);
    expect_time("R6 code 111", 0, 0, 0, 1, 1, 1, 30);
    wr_reg(8'h0A, 8'h66);
    repeat (2 * SEC) @(negedge clk);
    expect_time("R6 code 110", 0, 0, 0, 1, 1, 1, 30);
    wr_reg(8'h0A, 8'h26);
    repeat (HALF - 1) @(negedge clk);
    peek(8'h00, v); check("R7 after park", v, 8'h00);
    @(negedge clk);
    peek(8'h00, v); check("R7 after park update", v, 8'h01);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule